// File: doc/BRIEF.md
# Variable-Length Serial Peripheral Master

This block is a single-master SPI controller with one slave-select line that it drives by itself. Before a transfer the host sets the clock polarity, the clock phase, the word length and a clock divider on plain configuration inputs. It places the outgoing word on the transmit input and pulses `start`. The controller lowers slave select, shifts the word out most significant bit first, collects the bits returned by the slave, raises slave select again and reports completion with a one-cycle `done` pulse. The received word appears on `rxWord` in the same cycle.

The serial clock toggles only while a word is on the wire. At all other times it rests at the level that the polarity setting selects. The word length can change from one transfer to the next and may be anything from 4 to 32 bits. The configuration is captured when a transfer is accepted, so the host may change it while a transfer runs without disturbing that transfer.

Top module: `spi_len_master`

## Requirements
- R1: All four clock modes work. When `cfgCpha`=0 the master samples `miso` on the first (leading) clock edge of each bit and changes `mosi` on the second (trailing) edge. When `cfgCpha`=1 it changes `mosi` on the leading edge and samples on the trailing edge. `cfgCpol` sets the resting level of `sck`.
- R2: The effective length is `cfgLen` clamped into 4..32. A value below 4 acts as 4 and a value above 32 acts as 32. A transfer produces exactly twice the effective length of `sck` edges.
- R3: While `ssN` is high, `sck` sits at the `cfgCpol` value of the previous clock cycle and does not toggle.
- R4: `ssN` goes low at least one half `sck` period before the first `sck` edge. It returns high at least one half period after the last edge.
- R5: `busy` is high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle, and in that cycle `busy` is already low.
- R6: Transmission is MSB first. The low effective-length bits of `txWord` are sent. The received bits appear right-aligned in `rxWord` with every higher bit zero.
- R7: One half `sck` period lasts max(floor(`cfgDiv`/2), 1) system clock cycles, so a divider of 0 or 1 acts as 2 and an odd divider is rounded down.
- R8: A `start` pulse while `busy` is high is ignored. The configuration and transmit inputs may change during a transfer without affecting it.
- R9: After reset `ssN` is 1, and `busy`, `done` and `rxWord` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgCpol | input | 1 | Resting level of the serial clock |
| cfgCpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfgLen | input | LEN_W (6) | Requested word length in bits |
| cfgDiv | input | DIV_W (8) | Serial clock divider, in system cycles per period |
| txWord | input | MAX_LEN (32) | Word to transmit, right-aligned |
| start | input | 1 | Pulse that requests a transfer |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ssN | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rxWord | output | MAX_LEN (32) | Received word, right-aligned |

## Verification
The bench uses the default parameters: a 32-bit maximum word and an 8-bit divider. With these values the requested length field can go past 32 and below 4, so both clamps are exercised. Dividers from 0 to 9 cover the rounded odd values and the minimum half period of one cycle, where slave-select timing and edge spacing are tightest. A slave model in the bench follows the edges in all four modes, so every length from 4 to 32 can be checked in both directions.

// File: rtl/spi_len_pkg.sv
package spi_len_pkg;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic rest;      // idle: hold sck at the polarity level
    logic load;      // accept a new transfer
    logic toggle;    // flip sck this cycle
    logic shiftOut;  // advance the transmit register
    logic sampleIn;  // capture miso
    logic finish;    // publish the received word
  } spiStrobe_t;

  function automatic int clampLen(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/spi_len_ctrl.sv
module spi_len_ctrl
  import spi_len_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cfgCpha,
  input  logic [LEN_W-1:0] lenEff,
  input  logic [DIV_W-1:0] cfgDiv,
  output spiStrobe_t       strb,
  output logic             busy,
  output logic             ssN,
  output logic             done
);
  localparam int EDGE_W = LEN_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL} state_t;
  state_t state;

  logic [DIV_W-1:0]  halfLat, halfCnt, halfNew;
  logic [EDGE_W-1:0] edgeCnt, edgeLast;
  logic              cphaLat, tick, evenEdge;

  always_comb begin
    halfNew  = ((cfgDiv >> 1) == '0) ? DIV_W'(1) : (cfgDiv >> 1);
    tick     = (halfCnt == halfLat - DIV_W'(1));
    evenEdge = ~edgeCnt[0];
    strb.rest     = (state == ST_IDLE);
    strb.load     = (state == ST_IDLE) && start;
    strb.toggle   = (state == ST_XFER) && tick;
    strb.sampleIn = strb.toggle && (edgeCnt[0] == cphaLat);
    strb.shiftOut = strb.toggle &&
                    (cphaLat ? (evenEdge && edgeCnt != '0) : edgeCnt[0]);
    strb.finish   = (state == ST_TRAIL) && tick;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfLat  <= DIV_W'(1);
      halfCnt  <= '0;
      edgeCnt  <= '0;
      edgeLast <= '0;
      cphaLat  <= 1'b0;
      ssN      <= 1'b1;
      done     <= 1'b0;
    end else begin
      done    <= strb.finish;
      halfCnt <= (state == ST_IDLE || tick) ? '0 : halfCnt + DIV_W'(1);
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_LEAD;
          halfLat  <= halfNew;
          cphaLat  <= cfgCpha;
          edgeCnt  <= '0;
          edgeLast <= {lenEff, 1'b0} - EDGE_W'(1);
          ssN      <= 1'b0;
        end
        ST_LEAD: if (tick) state <= ST_XFER;
        ST_XFER: if (tick) begin
          edgeCnt <= edgeCnt + EDGE_W'(1);
          if (edgeCnt == edgeLast) state <= ST_TRAIL;
        end
        ST_TRAIL: if (tick) begin
          state <= ST_IDLE;
          ssN   <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_len_dpath.sv
module spi_len_dpath
  import spi_len_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  spiStrobe_t         strb,
  input  logic               cfgCpol,
  input  logic [LEN_W-1:0]   lenEff,
  input  logic [MAX_LEN-1:0] txWord,
  input  logic               miso,
  output logic               sck,
  output logic               mosi,
  output logic [MAX_LEN-1:0] rxWord
);
  logic [MAX_LEN-1:0] txSh, rxSh;
  logic [LEN_W-1:0]   padBits;

  assign padBits = LEN_W'(MAX_LEN) - lenEff;
  assign mosi    = txSh[MAX_LEN-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sck    <= 1'b0;
      txSh   <= '0;
      rxSh   <= '0;
      rxWord <= '0;
    end else begin
      if (strb.rest) sck <= cfgCpol;
      else if (strb.toggle) sck <= ~sck;
      if (strb.load) begin
        txSh <= txWord << padBits;
        rxSh <= '0;
      end else begin
        if (strb.shiftOut) txSh <= txSh << 1;
        if (strb.sampleIn) rxSh <= {rxSh[MAX_LEN-2:0], miso};
      end
      if (strb.finish) rxWord <= rxSh;
    end
  end
endmodule

// File: rtl/spi_len_master.sv
module spi_len_master
  import spi_len_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int MIN_LEN = 4,
  parameter int DIV_W   = 8,
  localparam int LEN_W  = $clog2(MAX_LEN) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgCpol,
  input  logic               cfgCpha,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic [DIV_W-1:0]   cfgDiv,
  input  logic [MAX_LEN-1:0] txWord,
  input  logic               start,
  input  logic               miso,
  output logic               sck,
  output logic               mosi,
  output logic               ssN,
  output logic               busy,
  output logic               done,
  output logic [MAX_LEN-1:0] rxWord
);
  spiStrobe_t       strb;
  logic [LEN_W-1:0] lenEff;

  assign lenEff = LEN_W'(clampLen(int'(cfgLen), MIN_LEN, MAX_LEN));

  spi_len_ctrl #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgCpha(cfgCpha),
    .lenEff(lenEff), .cfgDiv(cfgDiv), .strb(strb),
    .busy(busy), .ssN(ssN), .done(done)
  );

  spi_len_dpath #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgCpol(cfgCpol),
    .lenEff(lenEff), .txWord(txWord), .miso(miso),
    .sck(sck), .mosi(mosi), .rxWord(rxWord)
  );
endmodule

// File: rtl/spi_len_checker.sv
module spi_len_checker
  import spi_len_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int MIN_LEN = 4,
  parameter int LEN_W   = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgCpol,
  input logic [LEN_W-1:0]   cfgLen,
  input logic               start,
  input logic               sck,
  input logic               ssN,
  input logic               busy,
  input logic               done,
  input logic [MAX_LEN-1:0] rxWord
);
  logic             armed, sckPrev;
  logic [LEN_W:0]   seenEdges, expEdges;
  logic [LEN_W-1:0] lenLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      sckPrev   <= 1'b0;
      seenEdges <= '0;
      expEdges  <= '0;
      lenLat    <= LEN_W'(MIN_LEN);
    end else begin
      armed   <= 1'b1;
      sckPrev <= sck;
      if (start && !busy) begin
        lenLat    <= LEN_W'(clampLen(int'(cfgLen), MIN_LEN, MAX_LEN));
        expEdges  <= (LEN_W+1)'(2 * clampLen(int'(cfgLen), MIN_LEN, MAX_LEN));
        seenEdges <= '0;
      end else if (!ssN && sck != sckPrev) begin
        seenEdges <= seenEdges + 1'b1;
      end
    end
  end

  AST_SCK_RESTS: assert property (@(posedge clk) disable iff (!rstN)
    armed && ssN && $past(ssN) |-> sck == $past(cfgCpol)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy)); // R5

  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssN) |=> seenEdges == expEdges); // R2

  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rxWord >> lenLat) == '0); // R6
endmodule

bind spi_len_master spi_len_checker #(
  .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgLen(cfgLen),
  .start(start), .sck(sck), .ssN(ssN), .busy(busy), .done(done),
  .rxWord(rxWord)
);

// File: tb/tb_spi_len_master.sv
module tb_spi_len_master;
  localparam int MAX_LEN = 32;
  localparam int DIV_W   = 8;
  localparam int LEN_W   = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgCpol = 1'b0, cfgCpha = 1'b0, start = 1'b0, miso = 1'b0;
  logic [LEN_W-1:0] cfgLen = 6'd8;
  logic [DIV_W-1:0] cfgDiv = 8'd2;
  logic [31:0] txWord = '0;
  logic sck, mosi, ssN, busy, done;
  logic [31:0] rxWord;

  int total = 0, bad = 0;
  int cyc = 0;

  // bench-side model of the current transfer
  logic mCpol = 1'b0, mCpha = 1'b0;
  int   mLen = 8, mHalf = 1;
  logic [31:0] slaveWord = '0, sReg = '0, cap = '0;
  logic prevSck = 1'b0, prevSs = 1'b1;
  int   edges = 0, fallCyc = 0, firstEdgeCyc = 0, lastEdgeCyc = 0, riseCyc = 0;
  int   gapBad = 0;

  always #5 clk = ~clk;

  spi_len_master dut (
    .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgLen(cfgLen), .cfgDiv(cfgDiv), .txWord(txWord), .start(start),
    .miso(miso), .sck(sck), .mosi(mosi), .ssN(ssN), .busy(busy),
    .done(done), .rxWord(rxWord)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int effLen(input int req);
    return (req < 4) ? 4 : (req > 32) ? 32 : req;
  endfunction

  function automatic int effHalf(input int div);
    return ((div / 2) < 1) ? 1 : div / 2;
  endfunction

  function automatic logic [31:0] lenMask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  // slave model and timing monitor, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (prevSs && !ssN) begin
      sReg = slaveWord << (32 - mLen);
      cap = '0; edges = 0; gapBad = 0; fallCyc = cyc;
      if (!mCpha) begin miso = sReg[31]; sReg = sReg << 1; end
    end
    if (!ssN && sck != prevSck) begin
      automatic bit leading = (prevSck == mCpol);
      if (edges == 0) firstEdgeCyc = cyc;
      else if (cyc - lastEdgeCyc != mHalf) gapBad++;
      lastEdgeCyc = cyc;
      edges++;
      if (mCpha ? !leading : leading) cap = {cap[30:0], mosi};
      if (mCpha ? leading : !leading) begin miso = sReg[31]; sReg = sReg << 1; end
    end
    if (!prevSs && ssN) riseCyc = cyc;
    prevSck = sck;
    prevSs  = ssN;
  end

  task automatic runXfer(input bit cpol, input bit cpha, input int lenReq,
                         input int div, input logic [31:0] tx,
                         input logic [31:0] sw, input bit midStart);
    int waitN;
    int len = effLen(lenReq);
    int half = effHalf(div);
    string tag = midStart ? "R8" : "R1";
    @(negedge clk);
    cfgCpol = cpol; cfgCpha = cpha; cfgLen = LEN_W'(lenReq);
    cfgDiv = DIV_W'(div); txWord = tx; slaveWord = sw;
    mCpol = cpol; mCpha = cpha; mLen = len; mHalf = half;
    @(negedge clk);
    chk(sck == cpol && ssN, "R3 idle sck", {31'd0, sck}, {31'd0, cpol});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R5 busy after start", {31'd0, busy}, 32'd1);
    if (midStart) begin
      repeat (3) @(negedge clk);
      cfgCpol = ~cpol; cfgCpha = ~cpha; cfgLen = LEN_W'(len == 4 ? 32 : 4);
      cfgDiv = DIV_W'(div + 4); txWord = ~tx; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitN = 0;
    while (!done && waitN < 5000) begin @(negedge clk); waitN++; end
    chk(done == 1'b1, "R5 done seen", {31'd0, done}, 32'd1);
    chk(rxWord == (sw & lenMask(len)), {tag, " R6 rx word"}, rxWord, sw & lenMask(len));
    chk(busy == 1'b0, "R5 busy low at done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R5 done single", {31'd0, done}, 32'd0);
    chk(cap == (tx & lenMask(len)), {tag, " R6 mosi bits"}, cap, tx & lenMask(len));
    chk(edges == 2 * len, "R2 edge count", edges, 2 * len);
    chk(gapBad == 0, "R7 half period", gapBad, 0);
    chk(firstEdgeCyc - fallCyc >= half, "R4 lead time", firstEdgeCyc - fallCyc, half);
    chk(riseCyc - lastEdgeCyc >= half, "R4 trail time", riseCyc - lastEdgeCyc, half);
    cfgCpol = cpol;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(ssN == 1'b1, "R9 ssN reset", {31'd0, ssN}, 32'd1);
    chk(busy == 1'b0, "R9 busy reset", {31'd0, busy}, 32'd0);
    chk(done == 1'b0, "R9 done reset", {31'd0, done}, 32'd0);
    chk(rxWord == '0, "R9 rx reset", rxWord, 32'd0);

    // directed corners: all modes, length clamps, divider edges
    runXfer(0, 0, 8,  2, 32'h0000_00A5, 32'h0000_003C, 0);
    runXfer(0, 1, 4,  0, 32'h0000_0009, 32'h0000_0006, 0);
    runXfer(1, 0, 32, 1, 32'hDEAD_BEEF, 32'h1234_5678, 0);
    runXfer(1, 1, 16, 3, 32'h0000_C3E1, 32'h0000_7A5B, 0);
    runXfer(0, 0, 1,  4, 32'hFFFF_FFF3, 32'hFFFF_FFFA, 0);  // R2 low clamp
    runXfer(1, 1, 50, 2, 32'h8000_0001, 32'hF0F0_0F0F, 0);  // R2 high clamp
    runXfer(0, 1, 12, 5, 32'h0000_0ABC, 32'h0000_0321, 1);  // R8 start ignored
    runXfer(1, 0, 32, 6, 32'h5555_AAAA, 32'hCAFE_F00D, 1);  // R8

    for (int i = 0; i < 40; i++) begin
      runXfer($urandom % 2, $urandom % 2, $urandom % 41, $urandom % 10,
              $urandom, $urandom, ($urandom % 4) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule